// File: doc/BRIEF.md
# Asynchronous Static Memory Write Strobe Sequencer

This block turns a single write request into the timed control waveforms that an asynchronous static memory on an external bus expects. It drives the address bus, the 16-bit write data and its output-enable, and two active-low strobes: write-enable and chip-select. Each strobe has its own setup length and pulse length, counted in clock cycles. A total cycle length sets how long the write lasts. A mode input chooses which strobe governs the write, and that choice decides when the data drivers turn on.

A requester offers a write with a valid/ready handshake. The sequencer takes a new request only when it is idle or in the final cycle of the write in progress, so writes can follow one another with no gap. When a strobe has zero setup and zero hold, it stays low across consecutive writes. Timing values, mode, address and data are all captured when a request is accepted and are held for the whole write. A zero pulse value is illegal. It is run as a one-cycle pulse and sets a sticky error flag.

Top module: `wrgen_top`

## Requirements
- R1: `req_ready` is high exactly when no write is in progress or the write in progress is in its last cycle; a request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high.
- R2: `mem_addr` and `mem_dout` take the request's address and data on the accepting edge and do not change until the next accepting edge.
- R3: A write lasts L cycles, where L = max(`cyc_len`, we_setup + we_pulse, cs_setup + cs_pulse) using the effective pulses. Cycle index 0 is the first cycle after the accepting edge.
- R4: `mem_we_n` is low (0) in write cycle index c exactly when we_setup <= c < we_setup + we_pulse, and high (1) otherwise and when idle. It comes from a register.
- R5: `mem_cs_n` follows the same rule with cs_setup and cs_pulse. It comes from a register.
- R6: A strobe programmed with setup 0 and pulse equal to L stays low, with no high cycle, across back-to-back writes.
- R7: `mem_doe` is high from cycle index we_setup to the end of the write when the mode is 1 (write-enable governs), and from cycle index cs_setup to the end when the mode is 0 (chip-select governs). It is low when idle.
- R8: A pulse value of 0 on either strobe is run as 1. Accepting such a request sets `cfg_err` high, and `cfg_err` then stays high until reset.
- R9: While reset is high and after it is released, before any request: both strobes are high, `mem_doe` is low, `req_ready` is high, `cfg_err` is low, and `mem_addr` and `mem_dout` are zero.
- R10: Timing inputs and the mode input have no effect on a write in progress; only their values at the accepting edge apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Write address |
| req_data | input | 16 | Write data |
| we_ctrl_mode | input | 1 | 1: write-enable governs; 0: chip-select governs |
| we_setup | input | 6 | Write-enable setup cycles |
| we_pulse | input | 6 | Write-enable pulse cycles |
| cs_setup | input | 6 | Chip-select setup cycles |
| cs_pulse | input | 6 | Chip-select pulse cycles |
| cyc_len | input | 6 | Total write cycle length |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | 16 | External write data |
| mem_doe | output | 1 | Data output-enable |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_cs_n | output | 1 | Chip-select, active low |
| cfg_err | output | 1 | Sticky zero-pulse error |

## Verification
All outputs, including the error flag, come from registers loaded on the accepting edge. Write cycle index 0 is therefore visible one edge after acceptance, and each later index one edge further on. `req_ready` is combinational from state and is valid from that same point. The bench model advances on the same rising edge as the design, so every output is due one edge after the stimulus that caused it. The bench compares all outputs at each falling edge, half a period after that edge, and drives new inputs just after the falling edge. This keeps each check one edge behind the input that produced it.

// File: rtl/wrgen_pkg.sv
package wrgen_pkg;

    localparam int TIME_W  = 6;
    localparam int DATA_W  = 16;
    localparam int LEN_W   = TIME_W + 1;
    localparam int NUM_STB = 2;
    localparam int STB_WE  = 0;
    localparam int STB_CS  = 1;

    typedef logic [TIME_W-1:0] tval_t;
    typedef logic [LEN_W-1:0]  len_t;

    // Per-strobe timing.
    typedef struct packed {
        tval_t setup;
        tval_t pulse;
    } strobe_t;

    // Whole-write configuration, captured on acceptance.
    typedef struct packed {
        strobe_t [NUM_STB-1:0] stb;
        len_t                  len;
        logic                  we_ctrl;
    } wcfg_t;

    function automatic tval_t legal_pulse(tval_t p);
        return (p == '0) ? tval_t'(1) : p;
    endfunction

    function automatic len_t span(strobe_t s);
        return len_t'(s.setup) + len_t'(s.pulse);
    endfunction

    function automatic len_t max_len(len_t a, len_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wrgen_cfg_norm.sv
module wrgen_cfg_norm
    import wrgen_pkg::*;
(
    input  strobe_t [NUM_STB-1:0] raw_stb,
    input  tval_t                 raw_cyc,
    input  logic                  raw_we_ctrl,
    output wcfg_t                 cfg,
    output logic                  pulse_zero
);

    strobe_t [NUM_STB-1:0] fixed;
    logic    [NUM_STB-1:0] zero_hit;
    len_t    [NUM_STB:0]   run_max;

    assign run_max[0] = len_t'(raw_cyc);

    for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
        always_comb begin
            fixed[g].setup = raw_stb[g].setup;
            fixed[g].pulse = legal_pulse(raw_stb[g].pulse);
            zero_hit[g]    = (raw_stb[g].pulse == '0);
        end
        assign run_max[g+1] = max_len(run_max[g], span(fixed[g]));
    end

    always_comb begin
        cfg.stb     = fixed;
        cfg.len     = run_max[NUM_STB];
        cfg.we_ctrl = raw_we_ctrl;
        pulse_zero  = |zero_hit;
    end

endmodule

// File: rtl/wrgen_sequencer.sv
module wrgen_sequencer
    import wrgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  wcfg_t cfg_in,
    output logic  req_ready,
    output logic  accept,
    output logic  active,
    output logic  last,
    output logic  nxt_active,
    output len_t  nxt_cnt,
    output wcfg_t nxt_cfg
);

    len_t  cnt_q;
    wcfg_t cur_q;
    logic  act_q;

    always_comb begin
        last      = act_q && (cnt_q == len_t'(cur_q.len - len_t'(1)));
        req_ready = !act_q || last;
        accept    = req_valid && req_ready;
        active    = act_q;

        if (accept) begin
            nxt_active = 1'b1;
            nxt_cnt    = '0;
            nxt_cfg    = cfg_in;
        end else if (last) begin
            nxt_active = 1'b0;
            nxt_cnt    = '0;
            nxt_cfg    = cur_q;
        end else if (act_q) begin
            nxt_active = 1'b1;
            nxt_cnt    = cnt_q + len_t'(1);
            nxt_cfg    = cur_q;
        end else begin
            nxt_active = 1'b0;
            nxt_cnt    = '0;
            nxt_cfg    = cur_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            cur_q <= '0;
        end else begin
            act_q <= nxt_active;
            cnt_q <= nxt_cnt;
            cur_q <= nxt_cfg;
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (cnt_q < cur_q.len)); // R3

    AST_NO_TAKE_MIDWRITE: assert property (@(posedge clk) disable iff (rst)
        (act_q && !last) |=> (act_q && (cnt_q == $past(cnt_q) + len_t'(1)))); // R1

endmodule

// File: rtl/wrgen_strobe.sv
module wrgen_strobe
    import wrgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    nxt_active,
    input  len_t    nxt_cnt,
    input  strobe_t timing,
    output logic    strobe_n,
    output logic    setup_done
);

    len_t start_idx;
    len_t stop_idx;
    logic in_pulse;

    always_comb begin
        start_idx  = len_t'(timing.setup);
        stop_idx   = span(timing);
        in_pulse   = nxt_active && (nxt_cnt >= start_idx) && (nxt_cnt < stop_idx);
        setup_done = nxt_active && (nxt_cnt >= start_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) strobe_n <= 1'b1;
        else     strobe_n <= !in_pulse;
    end

endmodule

// File: rtl/wrgen_top.sv
module wrgen_top
    import wrgen_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              we_ctrl_mode,
    input  logic [TIME_W-1:0] we_setup,
    input  logic [TIME_W-1:0] we_pulse,
    input  logic [TIME_W-1:0] cs_setup,
    input  logic [TIME_W-1:0] cs_pulse,
    input  logic [TIME_W-1:0] cyc_len,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    output logic              mem_we_n,
    output logic              mem_cs_n,
    output logic              cfg_err
);

    strobe_t [NUM_STB-1:0] raw_stb;
    wcfg_t                 norm_cfg;
    logic                  pulse_zero;
    logic                  accept;
    logic                  active;
    logic                  last;
    logic                  nxt_active;
    len_t                  nxt_cnt;
    wcfg_t                 nxt_cfg;
    logic [NUM_STB-1:0]    stb_n;
    logic [NUM_STB-1:0]    stb_setup_done;
    logic                  doe_nxt;

    always_comb begin
        raw_stb[STB_WE].setup = we_setup;
        raw_stb[STB_WE].pulse = we_pulse;
        raw_stb[STB_CS].setup = cs_setup;
        raw_stb[STB_CS].pulse = cs_pulse;
    end

    wrgen_cfg_norm u_norm (
        .raw_stb     (raw_stb),
        .raw_cyc     (cyc_len),
        .raw_we_ctrl (we_ctrl_mode),
        .cfg         (norm_cfg),
        .pulse_zero  (pulse_zero)
    );

    wrgen_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .cfg_in     (norm_cfg),
        .req_ready  (req_ready),
        .accept     (accept),
        .active     (active),
        .last       (last),
        .nxt_active (nxt_active),
        .nxt_cnt    (nxt_cnt),
        .nxt_cfg    (nxt_cfg)
    );

    for (genvar g = 0; g < NUM_STB; g++) begin : g_strobe
        wrgen_strobe u_stb (
            .clk        (clk),
            .rst        (rst),
            .nxt_active (nxt_active),
            .nxt_cnt    (nxt_cnt),
            .timing     (nxt_cfg.stb[g]),
            .strobe_n   (stb_n[g]),
            .setup_done (stb_setup_done[g])
        );
    end

    assign mem_we_n = stb_n[STB_WE];
    assign mem_cs_n = stb_n[STB_CS];

    // The governing strobe's setup decides when the data drivers turn on.
    assign doe_nxt = nxt_cfg.we_ctrl ? stb_setup_done[STB_WE] : stb_setup_done[STB_CS];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_doe  <= 1'b0;
            mem_addr <= '0;
            mem_dout <= '0;
            cfg_err  <= 1'b0;
        end else begin
            mem_doe <= doe_nxt;
            if (accept) begin
                mem_addr <= req_addr;
                mem_dout <= req_data;
                if (pulse_zero) cfg_err <= 1'b1;
            end
        end
    end

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(mem_addr) && $stable(mem_dout))); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !active |-> (mem_we_n && mem_cs_n && !mem_doe)); // R5

    AST_DOE_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_doe && active && !last) |=> mem_doe); // R7

endmodule

// File: tb/sim_wrgen_top.sv
module sim_wrgen_top;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          we_ctrl_mode = 1'b1;
    logic [5:0]    we_setup = '0, we_pulse = 6'd1, cs_setup = '0, cs_pulse = 6'd1, cyc_len = 6'd1;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dout;
    logic          mem_doe, mem_we_n, mem_cs_n, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit cmp_on   = 0;
    bit b2b_mon  = 0;

    always #5 clk = ~clk;

    wrgen_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .we_ctrl_mode(we_ctrl_mode),
        .we_setup(we_setup), .we_pulse(we_pulse), .cs_setup(cs_setup),
        .cs_pulse(cs_pulse), .cyc_len(cyc_len), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_we_n(mem_we_n),
        .mem_cs_n(mem_cs_n), .cfg_err(cfg_err)
    );

    // Behavioural reference model
    int m_act = 0, m_cnt = 0, m_len = 0;
    int m_ws = 0, m_wp = 0, m_cs = 0, m_cp = 0, m_mode = 0;
    int m_err = 0;
    longint m_addr = 0, m_data = 0;

    function automatic int m_ready();
        return (m_act == 0 || m_cnt == m_len - 1) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_cnt = 0; m_err = 0; m_addr = 0; m_data = 0;
        end else if (req_valid && m_ready() == 1) begin
            m_ws = we_setup; m_cs = cs_setup;
            m_wp = (we_pulse == 0) ? 1 : int'(we_pulse);
            m_cp = (cs_pulse == 0) ? 1 : int'(cs_pulse);
            if (we_pulse == 0 || cs_pulse == 0) m_err = 1;
            m_len = cyc_len;
            if (m_ws + m_wp > m_len) m_len = m_ws + m_wp;
            if (m_cs + m_cp > m_len) m_len = m_cs + m_cp;
            m_mode = we_ctrl_mode;
            m_addr = req_addr; m_data = req_data;
            m_act = 1; m_cnt = 0;
        end else if (m_act == 1) begin
            if (m_cnt == m_len - 1) begin m_act = 0; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            int e_we, e_cs, e_doe;
            e_we  = (m_act == 1 && m_cnt >= m_ws && m_cnt < m_ws + m_wp) ? 0 : 1;
            e_cs  = (m_act == 1 && m_cnt >= m_cs && m_cnt < m_cs + m_cp) ? 0 : 1;
            e_doe = (m_act == 1 && m_cnt >= ((m_mode == 1) ? m_ws : m_cs)) ? 1 : 0;
            chk("R1 R3 req_ready", req_ready, m_ready());
            chk("R4 mem_we_n", mem_we_n, e_we);
            chk("R5 mem_cs_n", mem_cs_n, e_cs);
            chk("R7 R10 mem_doe", mem_doe, e_doe);
            chk("R2 mem_addr", mem_addr, m_addr);
            chk("R2 mem_dout", mem_dout, m_data);
            chk("R8 cfg_err", cfg_err, m_err);
            if (b2b_mon) begin
                chk("R6 we_n held low", mem_we_n, 0);
                chk("R6 cs_n held low", mem_cs_n, 0);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic mode,
                      int ws, int wp, int cs, int cp, int cl);
        req_addr = a; req_data = d; we_ctrl_mode = mode;
        we_setup = 6'(ws); we_pulse = 6'(wp); cs_setup = 6'(cs);
        cs_pulse = 6'(cp); cyc_len = 6'(cl);
        req_valid = 1'b1;
        while (!req_ready) step(1);
        step(1);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (!req_ready || mem_doe || !mem_we_n || !mem_cs_n) step(1);
        step(1);
    endtask

    initial begin
        step(1);
        cmp_on = 1;
        step(2);
        // R9: reset state
        chk("R9 reset we_n", mem_we_n, 1);
        chk("R9 reset cs_n", mem_cs_n, 1);
        chk("R9 reset doe", mem_doe, 0);
        chk("R9 reset ready", req_ready, 1);
        chk("R9 reset err", cfg_err, 0);
        rst = 1'b0;
        step(3);
        chk("R9 post-reset ready", req_ready, 1);

        // Write-enable governed, distinct strobe windows
        wr(24'h00_1234, 16'hA5A5, 1'b1, 2, 3, 1, 5, 8);
        drain();
        // Chip-select governed, same timing
        wr(24'h00_4321, 16'h5A5A, 1'b0, 2, 3, 1, 5, 8);
        drain();
        // R3: cycle length shorter than span is stretched
        wr(24'h0A_0001, 16'h0F0F, 1'b1, 3, 2, 0, 1, 2);
        drain();
        // R10: inputs scrambled during a write are ignored
        wr(24'h0B_0002, 16'h1111, 1'b0, 1, 4, 2, 2, 9);
        req_addr = 24'hFFFFFF; req_data = 16'hFFFF; we_ctrl_mode = 1'b1;
        we_setup = 6'd0; we_pulse = 6'd0; cs_setup = 6'd7; cyc_len = 6'd1;
        drain();
        chk("R10 no err from idle inputs", cfg_err, 0);
        // R6: zero setup and hold back-to-back
        wr(24'h00_0010, 16'h0001, 1'b1, 0, 4, 0, 4, 4);
        b2b_mon = 1;
        wr(24'h00_0011, 16'h0002, 1'b1, 0, 4, 0, 4, 4);
        wr(24'h00_0012, 16'h0003, 1'b0, 0, 4, 0, 4, 4);
        b2b_mon = 0;
        drain();
        // Back-to-back with setups, mode alternating
        wr(24'h00_0020, 16'h1234, 1'b1, 1, 2, 0, 4, 5);
        wr(24'h00_0021, 16'h2345, 1'b0, 2, 1, 1, 1, 3);
        wr(24'h00_0022, 16'h3456, 1'b1, 0, 1, 3, 2, 6);
        drain();
        // R8: zero pulse runs as one and latches error
        chk("R8 err clear before", cfg_err, 0);
        wr(24'h00_0030, 16'hBEEF, 1'b1, 2, 0, 0, 3, 4);
        drain();
        chk("R8 err set", cfg_err, 1);
        wr(24'h00_0031, 16'hCAFE, 1'b0, 1, 2, 1, 2, 4);
        drain();
        chk("R8 err sticky", cfg_err, 1);
        // Largest values
        wr(24'hFFFFFE, 16'hFFFE, 1'b1, 63, 63, 0, 63, 63);
        drain();
        rst = 1'b1;
        step(2);
        chk("R9 reset clears err", cfg_err, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 10);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule